// File: doc/BRIEF.md
# Gain-Scaled Delay Code Sequencer with Sign-Error Gain Adaptation

This block sits beside the feedback divider of a fractional-N synthesizer. The divider's delta-sigma modulator leaves a fractional phase residue on each reference cycle. The block multiplies that residue by an adaptive gain and rounds the product to a 9-bit word. The word drives a binary-weighted switched-capacitor delay line, which moves the divider edge so that the instantaneous ratio error is cancelled. The block runs on a fast clock. A one-cycle `ref_tick` marks each reference cycle.

The capacitors must be fully discharged before a new word is applied. For this reason every code update is a two-step sequence. First the word is held at zero for a programmable number of fast cycles. Then the new word is driven, and a one-cycle strobe accompanies it.

The gain is adapted with a sign-error LMS rule. The sign of the phase-detector error is correlated with whether the previous residue was at or above one half. The result decides whether the gain goes up or down by a power-of-two step. At equilibrium, full-scale delay equals one oscillator period. The gain can be frozen, individual updates can be skipped, and the result is kept between programmable limits.

Top module: `dtc_code_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the gain register loads `gain_init`. The code output, the strobe and the busy state clear. The stored residue sign clears to 0.
- R2: The new code is floor((qerr * G + 2^22) / 2^23). Here `qerr` is an unsigned 16-bit fraction of one, and G is the unsigned 16-bit gain (9 integer bits, 7 fraction bits) as it was before any update made on the same edge.
- R3: A rounded result above 511 is driven as 511.
- R4: On the edge that accepts a tick, the code output becomes 0. It stays 0 for exactly L cycles, where L is `rst_len`, with 0 read as 1. The new code then appears on the L-th edge after the accepting edge.
- R5: `code_stb` is high for exactly one cycle. That cycle is the one in which the new code first appears.
- R6: A tick is accepted only when no sequence is running. A tick that arrives during a sequence changes neither the code, nor the gain, nor the stored residue sign.
- R7: An update step is 2^(7-min(mu,7)) gain LSBs. The gain rises when `pd_late` equals the stored residue sign, and falls otherwise.
- R8: After the step, a result above `gain_max` becomes `gain_max`. A result below `gain_min` becomes `gain_min`.
- R9: While `cal_en` is low at an accepting edge, the gain is unchanged.
- R10: While `pd_valid` is low at an accepting edge, the gain is unchanged.
- R11: The stored residue sign is bit 15 of `qerr` at the most recent accepted tick. It is written on every accepted tick, whether or not the gain adapts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | One-cycle marker of a reference cycle |
| qerr | input | 16 | Modulator residue, unsigned fraction |
| pd_late | input | 1 | Phase-error sign, 1 = edge late |
| pd_valid | input | 1 | Phase-error sign is usable |
| cal_en | input | 1 | Gain adaptation enable |
| mu | input | 4 | Step exponent |
| gain_init | input | 16 | Gain loaded at reset |
| gain_min | input | 16 | Lower gain limit |
| gain_max | input | 16 | Upper gain limit |
| rst_len | input | 4 | Discharge length in fast cycles |
| dtc_code | output | 9 | Delay-line control word |
| code_stb | output | 1 | New word driven this cycle |
| gain | output | 16 | Current gain |

## Verification
On the accepting edge, the code product and the gain step both happen together. The code must use the old gain, and the gain must take the stepped and clamped value. The bench provokes this with calibration enabled, chooses residues whose products differ between the old and new gain, and compares both outputs against an independent per-cycle model. A second coincidence is a tick held high through the load edge. That tick must not be taken until the cycle after the strobe. It is produced both by a directed held tick and by random tick traffic, and the model judges every cycle.

// File: rtl/dtc_code_ctrl.sv
module dtc_code_ctrl #(
  parameter int QW = 16,
  parameter int GW = 16,
  parameter int GF = 7,
  parameter int CW = 9,
  parameter int LW = 4,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_tick,
  input  logic [QW-1:0] qerr,
  input  logic          pd_late,
  input  logic          pd_valid,
  input  logic          cal_en,
  input  logic [MW-1:0] mu,
  input  logic [GW-1:0] gain_init,
  input  logic [GW-1:0] gain_min,
  input  logic [GW-1:0] gain_max,
  input  logic [LW-1:0] rst_len,
  output logic [CW-1:0] dtc_code,
  output logic          code_stb,
  output logic [GW-1:0] gain
);
  localparam int PW = QW + GW;
  localparam int SH = QW + GF;
  localparam logic [PW:0]   HALF = (PW+1)'(1) << (SH - 1);
  localparam logic [PW:0]   CMAX = (PW+1)'((1 << CW) - 1);
  localparam logic [MW-1:0] GFM  = MW'(GF);

  logic [GW-1:0] gain_q;
  logic [CW-1:0] code_q, pend_q;
  logic [LW-1:0] cnt_q;
  logic          stb_q, busy_q, esgn_q;

  logic [PW:0]          rnd, scaled;
  logic [CW-1:0]        code_new;
  logic [MW-1:0]        mu_c;
  logic [GW+1:0]        step;
  logic signed [GW+1:0] gx;
  logic [GW-1:0]        g_nxt;
  logic [LW-1:0]        len_eff;

  wire acc = ref_tick & ~busy_q;
  wire upd = acc & cal_en & pd_valid;

  assign rnd      = (PW+1)'(qerr) * (PW+1)'(gain_q) + HALF;
  assign scaled   = rnd >> SH;
  assign code_new = (scaled > CMAX) ? {CW{1'b1}} : scaled[CW-1:0];

  assign mu_c    = (mu > GFM) ? GFM : mu;
  assign step    = (GW+2)'(1) << (GFM - mu_c);
  assign gx      = (pd_late == esgn_q) ? $signed({2'b00, gain_q}) + $signed(step)
                                       : $signed({2'b00, gain_q}) - $signed(step);
  assign len_eff = (rst_len == '0) ? LW'(1) : rst_len;

  always_comb begin
    if (gx > $signed({2'b00, gain_max}))      g_nxt = gain_max;
    else if (gx < $signed({2'b00, gain_min})) g_nxt = gain_min;
    else                                      g_nxt = gx[GW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q <= gain_init;
      code_q <= '0;
      pend_q <= '0;
      cnt_q  <= '0;
      stb_q  <= 1'b0;
      busy_q <= 1'b0;
      esgn_q <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (busy_q) begin
        if (cnt_q == LW'(1)) begin
          code_q <= pend_q;
          stb_q  <= 1'b1;
          busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - LW'(1);
        end
      end else if (ref_tick) begin
        pend_q <= code_new;
        esgn_q <= qerr[QW-1];
        cnt_q  <= len_eff;
        busy_q <= 1'b1;
        code_q <= '0;
        if (cal_en && pd_valid) gain_q <= g_nxt;
      end
    end
  end

  assign dtc_code = code_q;
  assign code_stb = stb_q;
  assign gain     = gain_q;

  p_zero_on_accept_r4: assert property (@(posedge clk) disable iff (rst)
    acc |=> (dtc_code == '0) && !code_stb);
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    code_stb |=> !code_stb);
  p_gain_in_bounds_r8: assert property (@(posedge clk) disable iff (rst)
    (upd && gain_min <= gain_max) |=> (gain >= $past(gain_min)) && (gain <= $past(gain_max)));
  p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    !cal_en |=> $stable(gain));
  p_skip_invalid_r10: assert property (@(posedge clk) disable iff (rst)
    !pd_valid |=> $stable(gain));
  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (rst)
    (ref_tick && busy_q) |=> $stable(gain) && $stable(pend_q));
endmodule

// File: tb/dtc_code_ctrl_tb.sv
module dtc_code_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic [15:0] qerr = '0;
  logic        pd_late = 1'b0, pd_valid = 1'b0, cal_en = 1'b0;
  logic [3:0]  mu = 4'd2;
  logic [15:0] gain_init = 16'd32768, gain_min = 16'd0, gain_max = 16'hFFFF;
  logic [3:0]  rst_len = 4'd3;
  logic [8:0]  dtc_code;
  logic        code_stb;
  logic [15:0] gain;

  int errors = 0, checks = 0;
  int m_gain, m_code, m_pend, m_cnt;
  bit m_stb, m_busy, m_esgn;

  always #(CLK_P/2) clk = ~clk;

  dtc_code_ctrl dut_i (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .qerr(qerr), .pd_late(pd_late),
    .pd_valid(pd_valid), .cal_en(cal_en), .mu(mu), .gain_init(gain_init),
    .gain_min(gain_min), .gain_max(gain_max), .rst_len(rst_len),
    .dtc_code(dtc_code), .code_stb(code_stb), .gain(gain));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ref_code(int q, int g);
    longint p;
    p = (longint'(q) * longint'(g) + (longint'(1) << 22)) >> 23;
    if (p > 511) p = 511;
    return int'(p);
  endfunction

  function automatic int ref_gain(int g, bit late, bit es, int m, int lo, int hi);
    int d, x;
    d = 1 << (7 - ((m > 7) ? 7 : m));
    x = (late == es) ? g + d : g - d;
    if (x > hi) x = hi;
    else if (x < lo) x = lo;
    return x;
  endfunction

  task automatic model_step();
    if (rst) begin
      m_gain = int'(gain_init); m_code = 0; m_pend = 0; m_cnt = 0;
      m_stb = 0; m_busy = 0; m_esgn = 0;
    end else begin
      m_stb = 0;
      if (m_busy) begin
        if (m_cnt == 1) begin m_code = m_pend; m_stb = 1; m_busy = 0; end
        else m_cnt--;
      end else if (ref_tick) begin
        m_pend = ref_code(int'(qerr), m_gain);
        if (cal_en && pd_valid)
          m_gain = ref_gain(m_gain, pd_late, m_esgn, int'(mu), int'(gain_min), int'(gain_max));
        m_esgn = qerr[15];
        m_cnt = (rst_len == 0) ? 1 : int'(rst_len);
        m_busy = 1; m_code = 0;
      end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    model_step();
    chk("R2/R4 code vs model", int'(dtc_code), m_code);
    chk("R5 strobe vs model", int'(code_stb), int'(m_stb));
    chk("R7/R8 gain vs model", int'(gain), m_gain);
  endtask

  task automatic do_reset(input int init);
    rst = 1'b1; gain_init = 16'(init); ref_tick = 1'b0;
    cyc(); cyc();
    chk("R1 reset code", int'(dtc_code), 0);
    chk("R1 reset strobe", int'(code_stb), 0);
    chk("R1 reset gain", int'(gain), init);
    rst = 1'b0;
  endtask

  task automatic run_tick(input int q, input bit late, input int exp_len, input int exp_code);
    int n;
    ref_tick = 1'b1; qerr = 16'(q); pd_late = late;
    cyc();
    ref_tick = 1'b0;
    chk("R4 zero after accept", int'(dtc_code), 0);
    n = 0;
    do begin cyc(); n++; end while (!code_stb && n < 40);
    chk("R4 discharge length", n, exp_len);
    chk("R2 code value", int'(dtc_code), exp_code);
    cyc();
    chk("R5 strobe width", int'(code_stb), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(32768);
    // R2, R4: frozen gain, several lengths
    cal_en = 0; pd_valid = 1; rst_len = 4'd3;
    run_tick(16'h8000, 0, 3, 128);
    rst_len = 4'd0;
    run_tick(16'h1234, 0, 1, 18);
    rst_len = 4'd15;
    run_tick(16'hFFFF, 0, 15, 256);
    chk("R9 frozen gain", int'(gain), 32768);
    rst_len = 4'd2;
    cal_en = 1; pd_valid = 0;
    run_tick(16'h1000, 1, 2, 16);
    chk("R10 invalid skip", int'(gain), 32768);
    // R7, R11: direction from stored residue sign
    pd_valid = 1; mu = 4'd2;
    run_tick(16'hC000, 0, 2, 192);
    chk("R7 step up", int'(gain), 32800);
    run_tick(16'h4000, 0, 2, 64);
    chk("R11 sign from previous residue", int'(gain), 32768);
    run_tick(16'h4000, 1, 2, 64);
    chk("R7 step down", int'(gain), 32736);
    mu = 4'd9;
    run_tick(16'h4000, 1, 2, 64);
    chk("R7 minimum step", int'(gain), 32735);
    // R8 clamp
    do_reset(32768);
    mu = 4'd2; gain_max = 16'd32808;
    run_tick(16'h1000, 0, 2, 16);
    run_tick(16'h1000, 0, 2, 16);
    chk("R8 upper clamp", int'(gain), 32808);
    gain_min = 16'd32760;
    run_tick(16'h1000, 1, 2, 16);
    run_tick(16'h1000, 1, 2, 16);
    chk("R8 lower clamp", int'(gain), 32760);
    // R3 saturation
    gain_min = 16'd0; gain_max = 16'hFFFF; cal_en = 0;
    do_reset(65535);
    run_tick(16'hFFFF, 0, 2, 511);
    run_tick(16'hFF00, 0, 2, 510);
    // R6 ticks during a sequence are ignored
    cal_en = 1; mu = 4'd2; rst_len = 4'd6;
    ref_tick = 1'b1; qerr = 16'h8000; pd_late = 0;
    cyc();
    qerr = 16'h0100;
    for (int i = 0; i < 3; i++) cyc();
    ref_tick = 1'b0;
    for (int i = 0; i < 3; i++) cyc();
    chk("R6 strobe after held tick", int'(code_stb), 1);
    chk("R6 code from first tick", int'(dtc_code), 256);
    chk("R6 single gain step", int'(gain), 65503);
    cyc();
    // random traffic against the model
    gain_min = 16'h0800; gain_max = 16'hFF00;
    do_reset(16'h4000);
    for (int i = 0; i < 4000; i++) begin
      ref_tick = ($urandom_range(0, 3) == 0);
      qerr     = 16'($urandom());
      pd_late  = 1'($urandom());
      pd_valid = ($urandom_range(0, 3) != 0);
      cal_en   = ($urandom_range(0, 5) != 0);
      mu       = 4'($urandom_range(0, 9));
      rst_len  = 4'($urandom());
      cyc();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule